// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Register Bank

This block drives four independent pulse-width modulated outputs from a single 32-bit memory-mapped register bank. Each channel counts ticks from a source chosen in its own mode register. The sources are four power-of-two strobes and two programmable strobes, all made by an external prescaler. The output is active while the count is below the programmed duty value. A channel can count in sawtooth fashion (left-aligned) or up then down (center-aligned, twice the period for the same period value). It can also invert its output level.

Channels start and stop through separate set and clear registers, and a status register shows which channels are running. Every time a running channel completes a period it latches a pending bit. Software opens a mask with a set register and closes it with a clear register, reads the mask back, and collects pending bits through a status register that empties when it is read. One combined interrupt line is raised when any pending bit is also unmasked. A 32-bit global configuration word is stored in the bank and presented on a port for the external prescaler.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After synchronous active-low reset, every register reads 0, no channel runs, the mask and pending bits are clear, `irq` is 0, `pwm_out` is 0 and `clk_cfg` is 0.
- R2: A write to byte offset 0x04 starts channel n for each 1 in bit n, and a write to 0x08 stops it. Zero bits leave the channel as it was. Offset 0x0C reads the running set in bits [3:0].
- R3: A write to 0x10 sets mask bit n for each 1 in bit n, and a write to 0x14 clears it. Zero bits have no effect. Offset 0x18 reads the mask.
- R4: A read of 0x1C returns the pending bits and clears them at the same clock edge. A period end that lands on that same edge stays pending.
- R5: `irq` is 1 exactly when some channel has both its pending bit and its mask bit set.
- R6: In left-aligned mode (mode bit 8 = 0) with period P, the counter steps 0..P-1 on each selected tick and then returns to 0. The pending bit is set when it returns to 0. A period of 0 behaves as a period of 1.
- R7: In center-aligned mode (mode bit 8 = 1), the counter rises 0..P-1, holds P-1 for one tick, falls back to 0, and holds 0 for one tick. The pending bit is set when it leaves that held 0, so one period lasts 2P ticks.
- R8: The output level is the polarity bit (mode bit 9) XOR (channel running AND counter < duty). A duty of 0 is never active, and a duty of at least the period is always active while running.
- R9: Mode bits [2:0] choose the tick source: 0..3 take `tick_pow[0..3]`, 4 takes `tick_a`, 5 takes `tick_b`, and 6 or 7 take no tick. Changing the source while running keeps the count.
- R10: Channel n's window starts at byte 0x200 + n*0x20 and holds mode at +0x00, duty at +0x04, period at +0x08 and counter at +0x0C. Duty and period keep their low 16 bits. Writes to the counter are ignored, and reads of addresses outside every window and global register return 0.
- R11: Offset 0x00 is a read/write 32-bit word whose value drives `clk_cfg`.
- R12: A stopped channel holds its counter at 0 and restarts from 0 counting upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_pow | input | 4 | Power-of-two tick strobes from the prescaler |
| tick_a | input | 1 | First programmable tick strobe |
| tick_b | input | 1 | Second programmable tick strobe |
| pwm_out | output | 4 | One modulated output per channel |
| irq | output | 1 | Combined interrupt request |
| clk_cfg | output | 32 | Global configuration word for the prescaler |

## Verification
The bench targets the read-to-clear status register while two channels end a period on every cycle. A design in which clearing beats setting returns 0 on a back-to-back second read where 6 is expected. It steps the counter one tick at a time through the turn-around points of center alignment. A design that reverses without the hold tick, or raises its event at the top, shows the wrong count or an early pending bit. Duty values of 0 and above the period check that the output does not toggle. The set/clear registers get writes whose zero bits touch a running channel; a design that treats them as plain registers stops it. A write to the read-only counter and a change of tick source mid-count would show up as a count that jumps.

// File: rtl/qpwm_pkg.sv
// Shared constants, the channel mode type and its register packing for the
// four-channel PWM controller. Assumes a 32-bit data bus and byte addresses.
package qpwm_pkg;

    // Global register byte offsets (software-visible map)
    localparam int unsigned OFF_CFG    = 'h00;
    localparam int unsigned OFF_RUNSET = 'h04;
    localparam int unsigned OFF_RUNCLR = 'h08;
    localparam int unsigned OFF_RUNSTS = 'h0C;
    localparam int unsigned OFF_MSKSET = 'h10;
    localparam int unsigned OFF_MSKCLR = 'h14;
    localparam int unsigned OFF_MSKSTS = 'h18;
    localparam int unsigned OFF_PEND   = 'h1C;

    // Channel windows
    localparam int unsigned CH_BASE   = 'h200;
    localparam int unsigned CH_STRIDE = 'h20;

    // Word selectors (byte offset / 4) inside the global block and a window
    localparam logic [2:0] G_CFG    = 3'd0;
    localparam logic [2:0] G_RUNSTS = 3'd3;
    localparam logic [2:0] G_MSKSTS = 3'd6;
    localparam logic [2:0] G_PEND   = 3'd7;
    localparam logic [2:0] W_MODE   = 3'd0;
    localparam logic [2:0] W_DUTY   = 3'd1;
    localparam logic [2:0] W_PER    = 3'd2;
    localparam logic [2:0] W_CNT    = 3'd3;

    // Tick source codes
    localparam int unsigned NPOW_TICKS = 4;
    localparam int unsigned SRC_W      = 3;
    localparam logic [SRC_W-1:0] SRC_TICK_A = 3'd4;
    localparam logic [SRC_W-1:0] SRC_TICK_B = 3'd5;

    // Mode field positions
    localparam int unsigned MODE_CENTER_BIT = 8;
    localparam int unsigned MODE_INV_BIT    = 9;

    typedef struct packed {
        logic             inv;
        logic             center;
        logic [SRC_W-1:0] src;
    } ch_mode_t;

    function automatic logic [31:0] mode_pack(ch_mode_t m);
        logic [31:0] w;
        w                  = '0;
        w[SRC_W-1:0]       = m.src;
        w[MODE_CENTER_BIT] = m.center;
        w[MODE_INV_BIT]    = m.inv;
        return w;
    endfunction

    function automatic ch_mode_t mode_unpack(logic [31:0] w);
        ch_mode_t m;
        m.src    = w[SRC_W-1:0];
        m.center = w[MODE_CENTER_BIT];
        m.inv    = w[MODE_INV_BIT];
        return m;
    endfunction

endpackage

// File: rtl/qpwm_channel.sv
// One PWM channel: selects a tick strobe, runs a left- or center-aligned
// counter, compares it with the duty value and flags each period end.
// Assumes tick strobes are single-cycle pulses synchronous to clk.
module qpwm_channel
    import qpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  ch_mode_t              mode,
    input  logic [CW-1:0]         duty,
    input  logic [CW-1:0]         period,
    input  logic [NPOW_TICKS-1:0] tick_pow,
    input  logic                  tick_a,
    input  logic                  tick_b,
    output logic [CW-1:0]         cnt,
    output logic                  pwm_o,
    output logic                  period_end
);

    localparam int PW = $clog2(NPOW_TICKS);

    logic          tick;
    logic          down;
    logic [CW-1:0] last;
    logic          at_top;

    // Pick the tick strobe named by the mode's source field
    always_comb begin
        if (int'(mode.src) < int'(NPOW_TICKS))
            tick = tick_pow[mode.src[PW-1:0]];
        else if (mode.src == SRC_TICK_A)
            tick = tick_a;
        else if (mode.src == SRC_TICK_B)
            tick = tick_b;
        else
            tick = 1'b0;
    end

    // Highest count of a period; a zero period acts as one tick
    always_comb begin
        last   = (period == '0) ? '0 : period - 1'b1;
        at_top = (cnt >= last);
    end

    // Period end: wrap in left mode, leaving the held zero in center mode
    always_comb begin
        if (mode.center)
            period_end = run & tick & down & (cnt == '0);
        else
            period_end = run & tick & at_top;
    end

    // Counter and direction update on each selected tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (tick) begin
            if (!mode.center) begin
                down <= 1'b0;
                cnt  <= at_top ? '0 : cnt + 1'b1;
            end else if (!down) begin
                if (at_top) down <= 1'b1;
                else        cnt  <= cnt + 1'b1;
            end else begin
                if (cnt == '0) down <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end
        end
    end

    // Output: active while below duty, then polarity applied
    always_comb pwm_o = mode.inv ^ (run & (cnt < duty));

endmodule

// File: rtl/qpwm_irq.sv
// Interrupt mask and pending bits: set/clear mask strobes, pending bits set
// by period ends and emptied by a status read, combined request output.
// Assumes only one of the mask strobes is active in a cycle.
module qpwm_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           msk_set,
    input  logic           msk_clr,
    input  logic           pend_rd,
    input  logic [NCH-1:0] sel,
    input  logic [NCH-1:0] ev,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] pend,
    output logic           irq
);

    // Mask register with write-one-to-set and write-one-to-clear access
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (msk_set) mask <= mask | sel;
        else if (msk_clr) mask <= mask & ~sel;
    end

    // Pending bits: a new event wins over the clear of a status read
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend_rd ? '0 : pend) | ev;
    end

    // Combined request from unmasked pending bits
    always_comb irq = |(pend & mask);

endmodule

// File: rtl/qpwm_regfile.sv
// Register bank: decodes the byte address, holds the global word, the run
// set and each channel's mode, duty and period, and returns registered
// read data. Assumes one access per cycle and word-aligned addresses.
module qpwm_regfile
    import qpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [AW-1:0]            bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NCH-1:0][CW-1:0]   cnt_all,
    input  logic [NCH-1:0]           mask,
    input  logic [NCH-1:0]           pend,
    output logic [NCH-1:0]           run,
    output logic [31:0]              cfg_word,
    output ch_mode_t [NCH-1:0]       mode_all,
    output logic [NCH-1:0][CW-1:0]   duty_all,
    output logic [NCH-1:0][CW-1:0]   per_all,
    output logic                     msk_set,
    output logic                     msk_clr,
    output logic                     pend_rd
);

    localparam int       IW      = AW - 5;
    localparam int       WIN_END = int'(CH_BASE) + NCH * int'(CH_STRIDE);

    logic          glb_hit;
    logic          win_hit;
    logic [2:0]    word;
    logic [AW-1:0] win_off;
    logic [IW-1:0] win_idx;
    logic [31:0]   rd_val;

    // Address decode into global block or a channel window
    always_comb begin
        word    = bus_addr[4:2];
        glb_hit = (bus_addr[AW-1:5] == '0);
        win_hit = (int'(bus_addr) >= int'(CH_BASE)) && (int'(bus_addr) < WIN_END);
        win_off = bus_addr - AW'(CH_BASE);
        win_idx = win_off[AW-1:5];
    end

    // Strobes toward the interrupt block
    always_comb begin
        msk_set = bus_wr && glb_hit && (int'(word) == int'(OFF_MSKSET / 4));
        msk_clr = bus_wr && glb_hit && (int'(word) == int'(OFF_MSKCLR / 4));
        pend_rd = bus_rd && glb_hit && (word == G_PEND);
    end

    // Global configuration word
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_word <= '0;
        else if (bus_wr && glb_hit && word == G_CFG)
            cfg_word <= bus_wdata;
    end

    // Run set with write-one-to-set and write-one-to-clear access
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= '0;
        else if (bus_wr && glb_hit && int'(word) == int'(OFF_RUNSET / 4))
            run <= run | bus_wdata[NCH-1:0];
        else if (bus_wr && glb_hit && int'(word) == int'(OFF_RUNCLR / 4))
            run <= run & ~bus_wdata[NCH-1:0];
    end

    // Per-channel writable registers; the counter word is read-only
    for (genvar i = 0; i < NCH; i++) begin : g_win
        logic hit;
        always_comb hit = bus_wr && win_hit && (win_idx == IW'(i));

        // Update this channel's mode, duty and period
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_all[i] <= '0;
                duty_all[i] <= '0;
                per_all[i]  <= '0;
            end else if (hit) begin
                case (word)
                    W_MODE:  mode_all[i] <= mode_unpack(bus_wdata);
                    W_DUTY:  duty_all[i] <= bus_wdata[CW-1:0];
                    W_PER:   per_all[i]  <= bus_wdata[CW-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; unmapped and write-only words return zero
    always_comb begin
        rd_val = '0;
        if (glb_hit) begin
            case (word)
                G_CFG:    rd_val = cfg_word;
                G_RUNSTS: rd_val = 32'(run);
                G_MSKSTS: rd_val = 32'(mask);
                G_PEND:   rd_val = 32'(pend);
                default:  rd_val = '0;
            endcase
        end else if (win_hit) begin
            for (int i = 0; i < NCH; i++) begin
                if (win_idx == IW'(i)) begin
                    case (word)
                        W_MODE:  rd_val = mode_pack(mode_all[i]);
                        W_DUTY:  rd_val = 32'(duty_all[i]);
                        W_PER:   rd_val = 32'(per_all[i]);
                        W_CNT:   rd_val = 32'(cnt_all[i]);
                        default: rd_val = '0;
                    endcase
                end
            end
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

endmodule

// File: rtl/quad_pwm_ctrl.sv
// Top of the four-channel PWM controller: register bank, one counter per
// channel and the interrupt logic. Tick strobes come from an external
// prescaler that is configured through clk_cfg.
module quad_pwm_ctrl
    import qpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [AW-1:0]         bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPOW_TICKS-1:0] tick_pow,
    input  logic                  tick_a,
    input  logic                  tick_b,
    output logic [NCH-1:0]        pwm_out,
    output logic                  irq,
    output logic [31:0]           clk_cfg
);

    logic [NCH-1:0]         run;
    logic [NCH-1:0]         mask;
    logic [NCH-1:0]         pend;
    logic [NCH-1:0]         ev;
    logic [NCH-1:0]         inv;
    logic [NCH-1:0][CW-1:0] cnt_all;
    logic [NCH-1:0][CW-1:0] duty_all;
    logic [NCH-1:0][CW-1:0] per_all;
    ch_mode_t [NCH-1:0]     mode_all;
    logic                   msk_set;
    logic                   msk_clr;
    logic                   pend_rd;

    qpwm_regfile #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_all   (cnt_all),
        .mask      (mask),
        .pend      (pend),
        .run       (run),
        .cfg_word  (clk_cfg),
        .mode_all  (mode_all),
        .duty_all  (duty_all),
        .per_all   (per_all),
        .msk_set   (msk_set),
        .msk_clr   (msk_clr),
        .pend_rd   (pend_rd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qpwm_channel #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run[i]),
            .mode       (mode_all[i]),
            .duty       (duty_all[i]),
            .period     (per_all[i]),
            .tick_pow   (tick_pow),
            .tick_a     (tick_a),
            .tick_b     (tick_b),
            .cnt        (cnt_all[i]),
            .pwm_o      (pwm_out[i]),
            .period_end (ev[i])
        );
        // Polarity bits gathered for the checker
        always_comb inv[i] = mode_all[i].inv;
    end

    qpwm_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .msk_set (msk_set),
        .msk_clr (msk_clr),
        .pend_rd (pend_rd),
        .sel     (bus_wdata[NCH-1:0]),
        .ev      (ev),
        .mask    (mask),
        .pend    (pend),
        .irq     (irq)
    );

endmodule

// File: rtl/qpwm_checker.sv
// Protocol and state checks for quad_pwm_ctrl, attached by bind.
module qpwm_checker #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [AW-1:0]          bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [NCH-1:0]         run,
    input logic [NCH-1:0]         mask,
    input logic [NCH-1:0]         pend,
    input logic [NCH-1:0]         ev,
    input logic [NCH-1:0]         inv,
    input logic [NCH-1:0][CW-1:0] cnt_all,
    input logic [NCH-1:0]         pwm_out,
    input logic                   irq
);

    a_r2_set_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h04)) |=>
        ((run & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    a_r2_clr_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h08)) |=>
        ((run & $past(bus_wdata[NCH-1:0])) == '0));

    a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h10)) |=>
        ((mask & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    a_r3_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'('h14)) |=>
        ((mask & $past(bus_wdata[NCH-1:0])) == '0));

    a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AW'('h1C)) |=> ((pend & ~$past(ev)) == '0));

    a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((pend & $past(ev)) == $past(ev)));

    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) == '0) |-> !irq);

    a_r5_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) != '0) |-> irq);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run[i] |-> (pwm_out[i] == inv[i]));

        a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !run[i] |=> (cnt_all[i] == '0));

        a_r6_no_event_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !run[i] |-> !ev[i]);
    end

endmodule

bind quad_pwm_ctrl qpwm_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_qpwm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run),
    .mask      (mask),
    .pend      (pend),
    .ev        (ev),
    .inv       (inv),
    .cnt_all   (cnt_all),
    .pwm_out   (pwm_out),
    .irq       (irq)
);

// File: tb/tb_quad_pwm_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares them
// with bus_rdata one edge later; pin checks are made directly.
module tb_quad_pwm_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_pow = '0;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic [3:0]  pwm_out;
    logic        irq;
    logic [31:0] clk_cfg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic rd_flag = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    quad_pwm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_pow(tick_pow), .tick_a(tick_a), .tick_b(tick_b),
        .pwm_out(pwm_out), .irq(irq), .clk_cfg(clk_cfg)
    );

    // Monitor: note reads at the edge, compare half a cycle later
    always @(posedge clk) rd_flag <= bus_rd;
    always @(negedge clk) begin
        if (rd_flag) begin
            item_t it;
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pin(input logic [31:0] act, input logic [31:0] e, input string tag);
        n_chk++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    task automatic pulse_a();
        @(negedge clk); tick_a = 1'b1;
        @(negedge clk); tick_a = 1'b0;
    endtask

    task automatic pulse_b();
        @(negedge clk); tick_b = 1'b1;
        @(negedge clk); tick_b = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        pin(32'(irq), 0, "R1 irq");
        pin(32'(pwm_out), 0, "R1 pwm_out");
        pin(clk_cfg, 0, "R1 clk_cfg");
        rd(12'h00C, 0, "R1 run status");
        rd(12'h018, 0, "R1 mask");
        rd(12'h01C, 0, "R1 pending");
        rd(12'h200, 0, "R1 ch0 mode");
        rd(12'h268, 0, "R1 ch3 period");

        // R11 global word
        wr(12'h000, 32'h1234_5678);
        rd(12'h000, 32'h1234_5678, "R11 readback");
        pin(clk_cfg, 32'h1234_5678, "R11 clk_cfg");

        // R10 window map, width, read-only counter, unmapped
        wr(12'h264, 32'h2A);
        wr(12'h268, 32'h0001_0005);
        rd(12'h264, 32'h2A, "R10 ch3 duty");
        rd(12'h268, 32'h5, "R10 ch3 period truncated");
        rd(12'h244, 0, "R10 ch2 duty untouched");
        rd(12'h280, 0, "R10 beyond last window");
        rd(12'h004, 0, "R10 write-only reads zero");

        // R6 left-aligned on tick_a, period 4 duty 2
        wr(12'h200, 32'h004);
        wr(12'h204, 32'd2);
        wr(12'h208, 32'd4);
        rd(12'h200, 32'h004, "R10 ch0 mode");
        wr(12'h004, 32'h1);
        rd(12'h00C, 32'h1, "R2 started");
        pin(32'(pwm_out[0]), 1, "R8 active at 0");
        pulse_a();
        wr(12'h20C, 32'd9);
        rd(12'h20C, 32'd1, "R10 counter write ignored");
        pin(32'(pwm_out[0]), 1, "R8 active at 1");
        pulse_a();
        pin(32'(pwm_out[0]), 0, "R8 inactive at 2");
        pulse_a();
        rd(12'h20C, 32'd3, "R6 count 3");
        rd(12'h01C, 0, "R6 no event before wrap");
        pulse_a();
        rd(12'h20C, 0, "R6 wrapped");
        rd(12'h01C, 32'h1, "R6 event at wrap");
        rd(12'h01C, 0, "R4 cleared by read");

        // R3 / R5 mask and interrupt
        wr(12'h010, 32'h1);
        rd(12'h018, 32'h1, "R3 mask set");
        pin(32'(irq), 0, "R5 no pending");
        repeat (4) pulse_a();
        pin(32'(irq), 1, "R5 pending and unmasked");
        rd(12'h01C, 32'h1, "R4 read");
        pin(32'(irq), 0, "R5 after clear");
        wr(12'h010, 32'h0);
        rd(12'h018, 32'h1, "R3 zero bits no effect");
        wr(12'h014, 32'h1);
        rd(12'h018, 0, "R3 mask cleared");
        repeat (4) pulse_a();
        pin(32'(irq), 0, "R5 masked pending");
        rd(12'h01C, 32'h1, "R4 masked still pending");

        // R2 / R12 zero bits and stopping
        pulse_a();
        wr(12'h004, 32'h0);
        wr(12'h008, 32'h2);
        rd(12'h00C, 32'h1, "R2 zero bits keep run");
        wr(12'h008, 32'h1);
        rd(12'h00C, 0, "R2 stopped");
        rd(12'h20C, 0, "R12 counter reset on stop");
        pin(32'(pwm_out[0]), 0, "R8 idle level");

        // R7 center-aligned, period 2 duty 1
        wr(12'h200, 32'h104);
        wr(12'h208, 32'd2);
        wr(12'h204, 32'd1);
        wr(12'h004, 32'h1);
        pin(32'(pwm_out[0]), 1, "R7 out at 0");
        pulse_a();
        rd(12'h20C, 32'd1, "R7 rising to 1");
        pin(32'(pwm_out[0]), 0, "R7 out at 1");
        pulse_a();
        rd(12'h20C, 32'd1, "R7 held at top");
        pulse_a();
        rd(12'h20C, 0, "R7 falling to 0");
        rd(12'h01C, 0, "R7 no event yet");
        pulse_a();
        rd(12'h01C, 32'h1, "R7 event after 2P ticks");
        rd(12'h20C, 0, "R7 held at 0");

        // R8 polarity, duty 0, duty above period
        wr(12'h200, 32'h304);
        pin(32'(pwm_out[0]), 0, "R8 inverted active");
        wr(12'h008, 32'h1);
        pin(32'(pwm_out[0]), 1, "R8 inverted idle");
        wr(12'h200, 32'h004);
        wr(12'h204, 32'd0);
        wr(12'h208, 32'd3);
        wr(12'h004, 32'h1);
        for (int k = 0; k < 3; k++) begin
            pin(32'(pwm_out[0]), 0, "R8 duty 0 never active");
            pulse_a();
        end
        wr(12'h204, 32'd5);
        for (int k = 0; k < 3; k++) begin
            pin(32'(pwm_out[0]), 1, "R8 duty above period");
            pulse_a();
        end
        rd(12'h01C, 32'h1, "R6 wraps while flat");
        wr(12'h008, 32'h1);

        // R9 tick source selection
        wr(12'h200, 32'h005);
        wr(12'h208, 32'd100);
        wr(12'h004, 32'h1);
        pulse_a();
        rd(12'h20C, 0, "R9 tick_a ignored on source 5");
        pulse_b();
        rd(12'h20C, 32'd1, "R9 tick_b counted");
        wr(12'h200, 32'h006);
        pulse_a();
        pulse_b();
        rd(12'h20C, 32'd1, "R9 source 6 no tick");
        wr(12'h200, 32'h002);
        @(negedge clk); tick_pow = 4'b0100;
        repeat (3) @(negedge clk);
        tick_pow = 4'b0000;
        rd(12'h20C, 32'd4, "R9 tick_pow[2] counted, count kept");
        wr(12'h008, 32'h1);
        rd(12'h01C, 0, "R9 no wrap on long period");

        // R4 collision of read clear with events, two channels
        tick_pow = 4'b0001;
        wr(12'h004, 32'h6);
        rd(12'h00C, 32'h6, "R2 two channels running");
        repeat (3) @(negedge clk);
        rd(12'h01C, 32'h6, "R4 events on both");
        rd(12'h01C, 32'h6, "R4 event beats clear");
        wr(12'h010, 32'h2);
        pin(32'(irq), 1, "R5 ch1 unmasked");
        wr(12'h008, 32'h6);
        tick_pow = 4'b0000;
        rd(12'h01C, 32'h6, "R4 last events");
        rd(12'h01C, 0, "R4 empty after stop");
        pin(32'(irq), 0, "R5 nothing pending");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule